// File: doc/BRIEF.md
# Flash Erase Suspend and Resume Sequencer

This block is the command-level sequencer of a flash memory model for a multi-block erase. A host picks blocks one at a time during a short selection window. When the window closes, the erase runs. The host may suspend the erase at any point and resume it later, as often as it needs to.

A block selected from idle opens the selection window. Each further selection adds its block to the erase set and restarts the window. A suspend during the window takes effect on the next cycle. A suspend during the running erase takes effect only after a fixed drain latency. While suspended, accesses to blocks outside the erase set behave normally, and reads inside the set are steered to the status path. Auto-select mode can be entered while suspended.

An abstract work counter stands in for cell-level timing. Each distinct block adds a fixed number of work units. Each `erase_tick` pulse consumes one unit, but only while the erase engine runs. When the counter reaches zero the block returns to read mode.

Top module: `erase_susp_ctrl`

## Requirements
- R1: After reset the block is in read mode with an empty erase set, `rd_sel` = 0 and `prog_ok` = 1. Mode codes on `mode` are: 0 read, 1 selection window, 2 erasing, 3 suspended, 4 auto-select in suspend, 5 erasing with suspend pending.
- R2: A `blk_sel` in mode 0 or 1 sets bit `blk_sel_idx` of `erase_mask` and moves to mode 1. Mode 2 begins exactly SEL_WIN cycles after the latest selection.
- R3: `cmd_suspend` in mode 1 gives mode 3 on the next cycle, and the mask is kept.
- R4: `cmd_suspend` in mode 2 gives mode 5, then mode 3 exactly SUSP_LAT cycles after the suspend cycle. `cmd_resume` in mode 5 has no effect.
- R5: `cmd_resume` in mode 3 gives mode 2 on the next cycle, whether the suspend came in mode 1 or in mode 2. A `blk_sel` in modes 2 to 5 leaves `erase_mask` unchanged.
- R6: Each distinct selected block adds BLK_WORK units of work, and a repeated selection adds none. `erase_tick` consumes one unit only in modes 2 and 5. The tick that consumes the last unit returns the block to mode 0 and clears `erase_mask`, even from mode 5.
- R7: `rd_sel` is 1 (status) in modes 1, 2 and 5 for any address. In mode 3 it is 1 if bit `addr_blk` of the mask is set and 0 (array) otherwise. In mode 4 it is 2 (auto-select). In mode 0 it is 0.
- R8: `prog_ok` is 1 in mode 0 and in mode 3 for a block outside the erase set, and 0 otherwise.
- R9: `cmd_autosel` in mode 3 gives mode 4. `cmd_reset` in mode 4 returns to mode 3, and `cmd_resume` in mode 4 is ignored.
- R10: `cmd_suspend` outside modes 1 and 2, and `cmd_resume` outside mode 3, leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_suspend | input | 1 | Decoded suspend strobe |
| cmd_resume | input | 1 | Decoded resume strobe |
| cmd_reset | input | 1 | Decoded read/reset strobe |
| cmd_autosel | input | 1 | Decoded auto-select entry strobe |
| blk_sel | input | 1 | Block selection event |
| blk_sel_idx | input | BLK_W | Block selected by `blk_sel` |
| erase_tick | input | 1 | One unit of erase work done by the timing engine |
| addr_blk | input | BLK_W | Block index of the current bus address |
| mode | output | 3 | Current mode code |
| erase_mask | output | NBLK | Blocks in the erase set |
| rd_sel | output | 2 | Read steering: 0 array, 1 status, 2 auto-select |
| prog_ok | output | 1 | A program to `addr_blk` may proceed |

## Verification
The assertions assume that the command decoder asserts at most one of the four command strobes in a cycle. They also assume that `blk_sel` never coincides with a command, because the sequencer resolves such overlaps by a fixed priority that the properties do not model. Every stimulus row and directed step of the bench drives at most one strobe or selection at a time. `erase_tick` is driven on its own, so each work unit can be traced to a specific cycle.

// File: rtl/erase_susp_ctrl.sv
module erase_susp_ctrl #(
  parameter int NBLK     = 8,
  parameter int SEL_WIN  = 6250,
  parameter int SUSP_LAT = 1875,
  parameter int BLK_WORK = 64,
  localparam int BLK_W   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int WIN_W   = $clog2(SEL_WIN + 1),
  localparam int LAT_W   = $clog2(SUSP_LAT + 1),
  localparam int WORK_W  = $clog2(NBLK * BLK_WORK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_suspend,
  input  logic             cmd_resume,
  input  logic             cmd_reset,
  input  logic             cmd_autosel,
  input  logic             blk_sel,
  input  logic [BLK_W-1:0] blk_sel_idx,
  input  logic             erase_tick,
  input  logic [BLK_W-1:0] addr_blk,
  output logic [2:0]       mode,
  output logic [NBLK-1:0]  erase_mask,
  output logic [1:0]       rd_sel,
  output logic             prog_ok
);

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_PEND  = 3'd1,
    M_ERASE = 3'd2,
    M_SUSP  = 3'd3,
    M_AUTO  = 3'd4,
    M_DRAIN = 3'd5
  } mode_t;

  mode_t             st_q;
  logic [NBLK-1:0]   mask_q;
  logic [WORK_W-1:0] work_q;
  logic [WIN_W-1:0]  win_q;
  logic [LAT_W-1:0]  lat_q;

  logic [NBLK-1:0] sel_bit;
  logic            new_blk;
  logic            running;
  logic            finish;

  assign sel_bit = NBLK'(1) << blk_sel_idx;
  assign new_blk = (mask_q & sel_bit) == '0;
  assign running = (st_q == M_ERASE) || (st_q == M_DRAIN);
  assign finish  = running && erase_tick && (work_q == WORK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_READ;
      mask_q <= '0;
      work_q <= '0;
      win_q  <= '0;
      lat_q  <= '0;
    end else begin
      case (st_q)
        M_READ: begin
          if (blk_sel) begin
            st_q   <= M_PEND;
            mask_q <= sel_bit;
            work_q <= WORK_W'(BLK_WORK);
            win_q  <= WIN_W'(SEL_WIN - 1);
          end
        end
        M_PEND: begin
          if (cmd_suspend) begin
            st_q <= M_SUSP;
          end else if (blk_sel) begin
            win_q <= WIN_W'(SEL_WIN - 1);
            if (new_blk) begin
              mask_q <= mask_q | sel_bit;
              work_q <= work_q + WORK_W'(BLK_WORK);
            end
          end else if (win_q == '0) begin
            st_q <= M_ERASE;
          end else begin
            win_q <= win_q - 1'b1;
          end
        end
        M_ERASE, M_DRAIN: begin
          if (finish) begin
            st_q   <= M_READ;
            mask_q <= '0;
            work_q <= '0;
          end else begin
            if (erase_tick) work_q <= work_q - 1'b1;
            if (st_q == M_ERASE) begin
              if (cmd_suspend) begin
                st_q  <= M_DRAIN;
                lat_q <= LAT_W'(SUSP_LAT - 1);
              end
            end else if (lat_q == '0) begin
              st_q <= M_SUSP;
            end else begin
              lat_q <= lat_q - 1'b1;
            end
          end
        end
        M_SUSP: begin
          if (cmd_resume)       st_q <= M_ERASE;
          else if (cmd_autosel) st_q <= M_AUTO;
        end
        M_AUTO: begin
          if (cmd_reset) st_q <= M_SUSP;
        end
        default: st_q <= M_READ;
      endcase
    end
  end

  assign mode       = st_q;
  assign erase_mask = mask_q;

  always_comb begin
    case (st_q)
      M_PEND, M_ERASE, M_DRAIN: rd_sel = 2'd1;
      M_SUSP:                   rd_sel = mask_q[addr_blk] ? 2'd1 : 2'd0;
      M_AUTO:                   rd_sel = 2'd2;
      default:                  rd_sel = 2'd0;
    endcase
  end

  assign prog_ok = (st_q == M_READ) || ((st_q == M_SUSP) && !mask_q[addr_blk]);

endmodule

// File: rtl/erase_susp_chk.sv
module erase_susp_chk #(
  parameter int NBLK     = 8,
  parameter int SUSP_LAT = 1875,
  localparam int BLK_W   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_suspend,
  input logic             cmd_resume,
  input logic             cmd_reset,
  input logic             cmd_autosel,
  input logic             blk_sel,
  input logic [BLK_W-1:0] addr_blk,
  input logic [2:0]       mode,
  input logic [NBLK-1:0]  erase_mask,
  input logic [1:0]       rd_sel,
  input logic             prog_ok
);

  int drain_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             drain_cyc <= 0;
    else if (mode == 3'd5)  drain_cyc <= drain_cyc + 1;
    else                    drain_cyc <= 0;
  end

  assert_read_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 |-> erase_mask == '0);

  assert_pend_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && cmd_suspend) |=> (mode == 3'd3 && $stable(erase_mask)));

  assert_drain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 |-> drain_cyc < SUSP_LAT);

  assert_drain_no_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && cmd_resume) |=> mode != 3'd2);

  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && cmd_resume) |=> mode == 3'd2);

  assert_mask_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd2 && mode <= 3'd5) |=> (mode == 3'd0 || $stable(erase_mask)));

  assert_status_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 || mode == 3'd5) |-> rd_sel == 2'd1);

  assert_prog_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ok && mode != 3'd0) |-> (mode == 3'd3 && rd_sel == 2'd0));

  assert_auto_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && cmd_reset) |=> mode == 3'd3);

  assert_idle_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !blk_sel) |=> mode == 3'd0);

  assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_suspend, cmd_resume, cmd_reset, cmd_autosel}));

  logic unused_ok;
  assign unused_ok = cmd_autosel ^ (|addr_blk);

endmodule

bind erase_susp_ctrl erase_susp_chk #(.NBLK(NBLK), .SUSP_LAT(SUSP_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
  .cmd_reset(cmd_reset), .cmd_autosel(cmd_autosel), .blk_sel(blk_sel),
  .addr_blk(addr_blk), .mode(mode), .erase_mask(erase_mask), .rd_sel(rd_sel),
  .prog_ok(prog_ok)
);

// File: tb/tb_erase_susp_ctrl.sv
module tb_erase_susp_ctrl;
  localparam int NBLK = 4;
  localparam int NV   = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0, cmd_autosel = 0;
  logic blk_sel = 0, erase_tick = 0;
  logic [1:0] blk_sel_idx = '0, addr_blk = '0;
  logic [2:0] mode;
  logic [NBLK-1:0] erase_mask;
  logic [1:0] rd_sel;
  logic prog_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  erase_susp_ctrl #(.NBLK(NBLK), .SEL_WIN(3), .SUSP_LAT(3), .BLK_WORK(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .cmd_reset(cmd_reset), .cmd_autosel(cmd_autosel), .blk_sel(blk_sel),
    .blk_sel_idx(blk_sel_idx), .erase_tick(erase_tick), .addr_blk(addr_blk),
    .mode(mode), .erase_mask(erase_mask), .rd_sel(rd_sel), .prog_ok(prog_ok)
  );

  // sus res rst aut _ sel idx _ tick _ addr _ mode _ rd_sel _ mask _ prog
  localparam logic [19:0] VEC [NV] = '{
    20'b0000_0_00_0_00_000_00_0000_1,
    20'b0000_1_01_0_00_001_01_0010_0,
    20'b0000_1_10_0_00_001_01_0110_0,
    20'b1000_0_00_0_10_011_01_0110_0,
    20'b0000_0_00_0_00_011_00_0110_1,
    20'b0000_1_11_0_11_011_00_0110_1,
    20'b0100_0_00_0_00_010_01_0110_0,
    20'b0000_1_00_0_00_010_01_0110_0,
    20'b0000_0_00_1_00_010_01_0110_0,
    20'b1000_0_00_0_00_101_01_0110_0,
    20'b0000_0_00_1_00_101_01_0110_0,
    20'b0100_0_00_0_00_101_01_0110_0,
    20'b0000_0_00_0_01_011_01_0110_0,
    20'b0000_0_00_1_00_011_00_0110_1,
    20'b0001_0_00_0_01_100_10_0110_0,
    20'b0100_0_00_0_01_100_10_0110_0,
    20'b0010_0_00_0_10_011_01_0110_0,
    20'b0100_0_00_0_00_010_01_0110_0,
    20'b0000_0_00_1_00_010_01_0110_0,
    20'b0000_0_00_1_01_000_00_0000_1,
    20'b1000_0_00_0_00_000_00_0000_1,
    20'b0100_0_00_0_00_000_00_0000_1
  };
  localparam string ROW_REQ [NV] = '{
    "R1", "R2", "R2", "R3", "R7", "R5", "R5", "R5", "R6", "R4", "R6",
    "R4", "R4", "R6", "R9", "R9", "R9", "R5", "R6", "R6", "R10", "R10"
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] in);
    {cmd_suspend, cmd_resume, cmd_reset, cmd_autosel, blk_sel, blk_sel_idx, erase_tick} = in[8:1];
    addr_blk = {1'b0, in[0]};
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    {cmd_suspend, cmd_resume, cmd_reset, cmd_autosel, blk_sel, erase_tick} = '0;
    blk_sel_idx = '0;
    addr_blk = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mode in reset", mode, 0);
    chk("R1", "mask in reset", erase_mask, 0);
    chk("R1", "rd_sel in reset", rd_sel, 0);
    chk("R1", "prog_ok in reset", prog_ok, 1);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      {cmd_suspend, cmd_resume, cmd_reset, cmd_autosel} = v[19:16];
      blk_sel = v[15];
      blk_sel_idx = v[14:13];
      erase_tick = v[12];
      addr_blk = v[11:10];
      step();
      chk(ROW_REQ[i], $sformatf("row %0d mode", i), mode, v[9:7]);
      chk("R7", $sformatf("row %0d rd_sel", i), rd_sel, v[6:5]);
      chk(ROW_REQ[i], $sformatf("row %0d mask", i), erase_mask, v[4:1]);
      chk("R8", $sformatf("row %0d prog_ok", i), prog_ok, v[0]);
    end
    idle();

    // R2 window timing, R6 repeated selection adds no work, completion from drain
    blk_sel = 1; blk_sel_idx = 2'd0; step();
    step();
    idle(); step();
    chk("R2", "window open after 1 idle", mode, 1);
    step();
    chk("R2", "window open after 2 idle", mode, 1);
    step();
    chk("R2", "erase starts after SEL_WIN", mode, 2);
    chk("R6", "repeat select mask", erase_mask, 1);
    erase_tick = 1; step();
    erase_tick = 0; cmd_suspend = 1; step();
    cmd_suspend = 0;
    chk("R4", "suspend enters drain", mode, 5);
    erase_tick = 1; step();
    erase_tick = 0;
    chk("R6", "finish during drain mode", mode, 0);
    chk("R6", "finish during drain mask", erase_mask, 0);
    step();
    chk("R10", "read stays idle", mode, 0);

    // R1 asynchronous reset mid erase
    blk_sel = 1; blk_sel_idx = 2'd3; step();
    idle();
    chk("R2", "new erase from read", erase_mask, 8);
    rst_n = 1'b0; #1;
    chk("R1", "reset clears mode", mode, 0);
    chk("R1", "reset clears mask", erase_mask, 0);
    rst_n = 1'b1;
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic unused_tb;
  assign unused_tb = ^{9'(0)} ;
  initial if (0) drive('0);
endmodule